// File: doc/BRIEF.md
# Transport Stream Sync Detector

This block sits on a byte-wide transport stream path that carries a byte-valid strobe. It looks for the 0x47 sync byte repeating every 188 valid bytes and, once the repetition is confirmed, flags the first byte of every aligned packet. Each input byte is passed through one register stage together with its valid bit and the packet-start flag. A downstream partial-stream controller uses that flag to tell where each packet begins.

Alignment is gained after three sync bytes in a row, each one 188 valid bytes after the one before. A single missing sync byte is tolerated. A second miss in a row sends the block back to searching. When the partial-stream mode input is high and a locked stream shows a packet whose length is not 188 bytes, the block raises a framing error and blocks its output. The error stays set until the mode input goes low or reset is applied.

Top module: `ts_sync_detector`

## Requirements
- R1: Every byte presented with `valid_i` high appears on `data_o` with `valid_o` high exactly one clock later, unless the framing error blocks it (R6). `sync_o`, `locked_o` and `frame_err_o` are aligned to that same output cycle.
- R2: The packet byte position advances only on cycles with `valid_i` high. A cycle with `valid_i` low gives `valid_o` and `sync_o` low one cycle later, whatever the data value, and it does not shift the packet grid.
- R3: `locked_o` rises in the output cycle of the third consecutive 0x47 byte, where each of those bytes follows the previous one after exactly 188 valid bytes. That third byte is flagged on `sync_o`.
- R4: `sync_o` is high only while locked, and only on a 0x47 byte at the expected packet-start position. It is never high while searching or verifying, and never high on a 0x47 byte anywhere else in the packet.
- R5: While locked, one expected position without 0x47 keeps the lock. A second consecutive miss drops `locked_o` in the output cycle of that second byte, and the block goes back to searching for a new 0x47.
- R6: When `partial_mode_i` is high, the block is locked and the byte at the expected position is not 0x47, `frame_err_o` rises in that byte's output cycle. From that byte on, `valid_o` and `sync_o` stay low while `frame_err_o` is high.
- R7: `frame_err_o` is sticky. It clears on the first output cycle after a byte cycle in which `partial_mode_i` is low, or on reset. With `partial_mode_i` low, no error is raised and the stream passes through.
- R8: While searching, a non-0x47 byte never raises `frame_err_o`, even when `partial_mode_i` is high.
- R9: While `rst_ni` is low, all outputs are zero and the block is searching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Incoming stream byte |
| valid_i | input | 1 | Byte strobe for `data_i` |
| partial_mode_i | input | 1 | Partial-stream mode: enables the framing-error cut-off |
| data_o | output | 8 | Byte delayed by one cycle |
| valid_o | output | 1 | Output byte strobe, gated by the framing error |
| sync_o | output | 1 | High on the first byte of an aligned packet |
| locked_o | output | 1 | Packet alignment confirmed |
| frame_err_o | output | 1 | Sticky framing error in partial-stream mode |

## Verification
All of this block's results are due one clock after the byte that causes them. This holds for the data, valid and sync flag, for lock gain and loss, and for the rise or clear of the framing error. The bench drives each byte on the falling edge and samples every output shortly after the next rising edge, so each sample belongs to exactly one input byte. Idle cycles with a 0x47 value on the data bus are mixed into the packets. This shows that only valid bytes move the 188-byte grid and that idle cycles never produce a flag.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } sync_state_e;
endpackage

// File: rtl/ts_pos_counter.sv
module ts_pos_counter #(
  parameter int PKT_LEN = 188
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic restart_i,
  output logic at_start_o
);
  localparam int CW = $clog2(PKT_LEN);
  localparam logic [CW-1:0] LAST = CW'(PKT_LEN - 1);

  logic [CW-1:0] pos_q;

  // pos_q is the index of the next valid byte within the packet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (valid_i) begin
      if (restart_i)          pos_q <= CW'(1);
      else if (pos_q == LAST) pos_q <= '0;
      else                    pos_q <= pos_q + CW'(1);
    end
  end

  assign at_start_o = (pos_q == '0);
endmodule

// File: rtl/ts_lock_fsm.sv
module ts_lock_fsm
  import ts_sync_pkg::*;
#(
  parameter int LOCK_HITS   = 3,  // must be 2 or more
  parameter int LOSS_MISSES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        is_sync_i,
  input  logic        at_start_i,
  output sync_state_e state_o,
  output logic        restart_o,
  output logic        mark_o,
  output logic        miss_o
);
  localparam int HW = $clog2(LOCK_HITS + 1);
  localparam int MW = $clog2(LOSS_MISSES + 1);
  localparam logic [HW-1:0] HIT_LAST  = HW'(LOCK_HITS - 1);
  localparam logic [MW-1:0] MISS_LAST = MW'(LOSS_MISSES - 1);

  sync_state_e   st_q, st_d;
  logic [HW-1:0] hit_q, hit_d;
  logic [MW-1:0] miss_q, miss_d;

  always_comb begin
    st_d      = st_q;
    hit_d     = hit_q;
    miss_d    = miss_q;
    restart_o = 1'b0;
    mark_o    = 1'b0;
    miss_o    = 1'b0;
    if (valid_i) begin
      unique case (st_q)
        ST_SEARCH: begin
          if (is_sync_i) begin
            restart_o = 1'b1;
            hit_d     = HW'(1);
            st_d      = ST_VERIFY;
          end
        end
        ST_VERIFY: begin
          if (at_start_i) begin
            if (!is_sync_i) begin
              st_d = ST_SEARCH;
            end else if (hit_q == HIT_LAST) begin
              st_d   = ST_LOCKED;
              miss_d = '0;
              mark_o = 1'b1;
            end else begin
              hit_d = hit_q + HW'(1);
            end
          end
        end
        ST_LOCKED: begin
          if (at_start_i) begin
            if (is_sync_i) begin
              mark_o = 1'b1;
              miss_d = '0;
            end else begin
              miss_o = 1'b1;
              if (miss_q == MISS_LAST) begin
                st_d   = ST_SEARCH;
                miss_d = '0;
              end else begin
                miss_d = miss_q + MW'(1);
              end
            end
          end
        end
        default: st_d = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SEARCH;
      hit_q  <= '0;
      miss_q <= '0;
    end else begin
      st_q   <= st_d;
      hit_q  <= hit_d;
      miss_q <= miss_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/ts_frame_guard.sv
module ts_frame_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic partial_mode_i,
  input  logic violation_i,
  output logic err_next_o,
  output logic err_o
);
  logic err_q;

  // sticky while partial mode stays on
  assign err_next_o = partial_mode_i & (err_q | (valid_i & violation_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_next_o;
  end

  assign err_o = err_q;
endmodule

// File: rtl/ts_sync_detector.sv
module ts_sync_detector
  import ts_sync_pkg::*;
#(
  parameter int          PKT_LEN     = 188,
  parameter logic [7:0]  SYNC_BYTE   = 8'h47,
  parameter int          LOCK_HITS   = 3,
  parameter int          LOSS_MISSES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  input  logic       partial_mode_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       sync_o,
  output logic       locked_o,
  output logic       frame_err_o
);
  sync_state_e state;
  logic        is_sync, at_start, restart, mark, miss, err_next;
  logic [7:0]  data_q;
  logic        valid_q, sync_q;

  assign is_sync = (data_i == SYNC_BYTE);

  ts_pos_counter #(.PKT_LEN(PKT_LEN)) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .restart_i  (restart),
    .at_start_o (at_start)
  );

  ts_lock_fsm #(.LOCK_HITS(LOCK_HITS), .LOSS_MISSES(LOSS_MISSES)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .is_sync_i  (is_sync),
    .at_start_i (at_start),
    .state_o    (state),
    .restart_o  (restart),
    .mark_o     (mark),
    .miss_o     (miss)
  );

  ts_frame_guard u_guard (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .valid_i        (valid_i),
    .partial_mode_i (partial_mode_i),
    .violation_i    (miss),
    .err_next_o     (err_next),
    .err_o          (frame_err_o)
  );

  // single output stage; the offending byte is already suppressed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      data_q  <= data_i;
      valid_q <= valid_i & ~err_next;
      sync_q  <= mark & ~err_next;
    end
  end

  assign data_o   = data_q;
  assign valid_o  = valid_q;
  assign sync_o   = sync_q;
  assign locked_o = (state == ST_LOCKED);
endmodule

// File: rtl/ts_sync_detector_chk.sv
module ts_sync_detector_chk #(
  parameter logic [7:0] SYNC_BYTE = 8'h47
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] data_i,
  input logic       valid_i,
  input logic       partial_mode_i,
  input logic [7:0] data_o,
  input logic       valid_o,
  input logic       sync_o,
  input logic       locked_o,
  input logic       frame_err_o
);
  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(valid_i) && data_o == $past(data_i)));

  a_r2_idle_no_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !sync_o));

  a_r3_lock_rise_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> sync_o);

  a_r4_sync_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> (locked_o && valid_o && data_o == SYNC_BYTE));

  a_r6_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> (!valid_o && !sync_o));

  a_r7_mode_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !partial_mode_i |=> !frame_err_o);

  a_r8_no_err_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_err_o) |-> $past(locked_o));

  a_r9_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !sync_o && !locked_o && !frame_err_o));
endmodule

bind ts_sync_detector ts_sync_detector_chk #(.SYNC_BYTE(SYNC_BYTE)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .data_i         (data_i),
  .valid_i        (valid_i),
  .partial_mode_i (partial_mode_i),
  .data_o         (data_o),
  .valid_o        (valid_o),
  .sync_o         (sync_o),
  .locked_o       (locked_o),
  .frame_err_o    (frame_err_o)
);

// File: tb/ts_sync_detector_bench.sv
module ts_sync_detector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PKT_LEN    = 188;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       valid_i = 1'b0;
  logic       partial_mode_i = 1'b0;
  logic [7:0] data_o;
  logic       valid_o, sync_o, locked_o, frame_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ts_sync_detector u_ts_sync_detector (
    .clk_i, .rst_ni, .data_i, .valid_i, .partial_mode_i,
    .data_o, .valid_o, .sync_o, .locked_o, .frame_err_o
  );

  // {first byte, mode, exp valid, exp sync, exp locked, exp err}
  localparam int NVEC = 15;
  localparam logic [12:0] VEC [NVEC] = '{
    {8'h47, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 first hit
    {8'h47, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 second hit, no flag yet (R4)
    {8'h47, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R3 lock on third
    {8'h47, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R4
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 single miss keeps lock, R7 no err
    {8'h47, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R5 recovered
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 miss 1
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 miss 2 drops lock
    {8'h47, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R4 search, no flag
    {8'h47, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h47, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R3 relock
    {8'h47, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},  // R6 mode on, good framing
    {8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R6 bad length blocks output
    {8'h47, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R7 sticky
    {8'h47, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}   // R7 mode off clears
  };

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got v%0b s%0b l%0b e%0b d%02h, expected v%0b s%0b l%0b e%0b d%02h",
               req, act[11], act[10], act[9], act[8], act[7:0],
               exp[11], exp[10], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic cycle(logic [7:0] d, logic v, logic m);
    @(negedge clk_i);
    data_i = d; valid_i = v; partial_mode_i = m;
    @(posedge clk_i);
    #1;
  endtask

  // one packet; stray_pos > 0 puts a 0x47 filler at that index
  task automatic send_pkt(string req, logic [7:0] first, logic m,
                          logic ev, logic es, logic el, logic ee, int stray_pos);
    cycle(first, 1'b1, m);
    check(req, {valid_o, sync_o, locked_o, frame_err_o, data_o},
               {ev, es, el, ee, first});
    for (int i = 1; i < PKT_LEN; i++) begin
      logic [7:0] f;
      if (i % 61 == 30) begin
        cycle(8'h47, 1'b0, m);  // R2 idle cycle with sync value
        check("R2", {valid_o, sync_o, locked_o, frame_err_o, 8'h00},
                    {1'b0, 1'b0, el, ee, 8'h00});
      end
      f = (i == stray_pos) ? 8'h47 : 8'((i * 5) & 8'h3F);
      cycle(f, 1'b1, m);
      check((i == stray_pos) ? "R4" : "R1",
            {valid_o, sync_o, locked_o, frame_err_o, data_o},
            {~ee, 1'b0, el, ee, f});
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; valid_i = 1'b0; partial_mode_i = 1'b0;
    #1;
    check("R9", {valid_o, sync_o, locked_o, frame_err_o, data_o}, 12'h000);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9", {valid_o, sync_o, locked_o, frame_err_o, data_o}, 12'h000);
    rst_ni = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      send_pkt("R1", VEC[k][12:5], VEC[k][4], VEC[k][3], VEC[k][2],
               VEC[k][1], VEC[k][0], 0);
    end

    // R4: stray 0x47 mid-packet while locked is not flagged
    send_pkt("R4", 8'h47, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 100);

    // R9: reset mid-stream drops lock
    do_reset();
    // R8: searching with partial mode on never errors
    send_pkt("R8", 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    send_pkt("R8", 8'h12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0);

    // build an error, then clear it by reset
    send_pkt("R3", 8'h47, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    send_pkt("R3", 8'h47, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    send_pkt("R3", 8'h47, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    send_pkt("R6", 8'h33, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0);
    do_reset();
    cycle(8'h47, 1'b1, 1'b1);
    check("R9", {valid_o, sync_o, locked_o, frame_err_o, data_o},
                {1'b1, 1'b0, 1'b0, 1'b0, 8'h47});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule